// File: doc/BRIEF.md
# CPU Status Flag Unit

This block keeps the 8-bit status register of a small processor core. After each arithmetic or logic step the ALU presents its result, the carry out of the top bit, the carry or borrow at bit 3, and the sign bits of its operands. It also names an operation class and whether the step was byte-wide or word-wide. The unit then rewrites carry, zero, sign, overflow, half-carry and the add/subtract marker that a later decimal-adjust step uses. Single-flag commands set, clear or toggle carry and pick the memory space bit. A direct write loads the whole register.

An internal LIFO of seven entries saves the register on interrupt entry and restores it on return, so nested handlers come back to the status they interrupted. Misuse of the LIFO sets a sticky error output. The LIFO never corrupts saved copies.

Top module: `status_flag_unit`

## Requirements
- R1: After reset `flags` is 8'h00. The bit layout, MSB first, is C(7) Z(6) S(5) V(4) DA(3) H(2) reserved(1) DP(0).
- R2: Bit 1 always reads 0, even after a write of 1 to it.
- R3: On an update of class add (0), subtract (1) or shift (2), C takes `cy_msb`. For every class, S takes res[7] on a byte step (`op_word`=0) and res[15] on a word step (`op_word`=1).
- R4: On any update, Z is 1 exactly when res[7:0] is zero (byte) or res[15:0] is zero (word). Bits above the selected width are ignored.
- R5: V is set as follows. For add: `a_neg`==`b_neg` and S differs from `a_neg`. For subtract: `a_neg`!=`b_neg` and S differs from `a_neg`. For shift: S differs from `a_neg`.
- R6: A byte add or subtract loads H from `cy_b3`. Word steps, shifts and logic steps leave H unchanged.
- R7: Add clears DA and subtract sets DA. Shift and logic steps leave DA unchanged.
- R8: A logic/test step (class 3) updates Z and S, clears V, and leaves C, H and DA unchanged.
- R9: `cmd` acts on C and DP. The codes are 1 set C, 2 clear C, 3 toggle C, 4 set DP, 5 clear DP, and 0 none. DP changes only through `cmd` or a write.
- R10: When `wr_en` is high, the register takes `wr_data` (bit 1 forced to 0) on the next edge. This overrides any update, command or pop in the same cycle.
- R11: `irq_push` saves the current register. `irq_pop` restores the most recently saved copy. Up to seven nested copies come back in reverse order.
- R12: Any of the following raises `stk_err`: a push with seven copies stored, a pop with none stored, or a push and a pop together. The error stays set until reset, and the saved copies and the register are unchanged by that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Apply ALU result this cycle |
| op_class | input | 2 | 0 add, 1 subtract, 2 shift/rotate, 3 logic/test |
| op_word | input | 1 | 1 = word width, 0 = byte width |
| res | input | 16 | ALU result |
| cy_msb | input | 1 | Carry out of the top bit of the selected width |
| cy_b3 | input | 1 | Carry out of / borrow into bit 3 |
| a_neg | input | 1 | Sign of first operand at selected width |
| b_neg | input | 1 | Sign of second operand at selected width |
| cmd | input | 3 | Single-flag command code |
| wr_en | input | 1 | Direct register write |
| wr_data | input | 8 | Write data |
| irq_push | input | 1 | Interrupt entry: save register |
| irq_pop | input | 1 | Interrupt return: restore register |
| flags | output | 8 | Status register |
| stk_err | output | 1 | Sticky save-stack misuse |

## Verification
A wrong flag computation shows on `flags` one edge after the update that caused it. The vector walk preloads the register through a write, so each update is judged against a known starting value, which also exposes flags that should have been held. A broken save stack or depth count stays hidden until the pops. The nesting test therefore fills all seven levels and drains them, and each restored value is compared in the cycle after its pop. The misuse checks confirm that `stk_err` is raised in the cycle after the bad request and that the saved order is not disturbed.

// File: rtl/status_flag_unit.sv
module status_flag_unit #(
  parameter int DW   = 16,
  parameter int LVLS = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [1:0]    op_class,
  input  logic          op_word,
  input  logic [DW-1:0] res,
  input  logic          cy_msb,
  input  logic          cy_b3,
  input  logic          a_neg,
  input  logic          b_neg,
  input  logic [2:0]    cmd,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          irq_push,
  input  logic          irq_pop,
  output logic [7:0]    flags,
  output logic          stk_err
);
  localparam int CW = $clog2(LVLS + 1);
  localparam int C_B = 7, Z_B = 6, S_B = 5, V_B = 4, DA_B = 3, H_B = 2, DP_B = 0;

  logic [7:0]    flg, nxt;
  logic [7:0]    stk [LVLS];
  logic [CW-1:0] cnt;

  wire r_s    = op_word ? res[DW-1] : res[7];
  wire r_z    = op_word ? (res == '0) : (res[7:0] == 8'h00);
  wire full   = (cnt == CW'(LVLS));
  wire empty  = (cnt == '0);
  wire push_ok = irq_push && !irq_pop && !full;
  wire pop_ok  = irq_pop && !irq_push && !empty;
  wire bad     = (irq_push && irq_pop) || (irq_push && full) || (irq_pop && empty);
  wire [CW-1:0] top = cnt - CW'(1);

  always_comb begin
    nxt = flg;
    if (op_valid) begin
      nxt[Z_B] = r_z;
      nxt[S_B] = r_s;
      unique case (op_class)
        2'd0, 2'd1: begin
          nxt[C_B]  = cy_msb;
          nxt[V_B]  = (op_class == 2'd0) ? ((a_neg == b_neg) && (r_s != a_neg))
                                         : ((a_neg != b_neg) && (r_s != a_neg));
          nxt[DA_B] = op_class[0];
          if (!op_word) nxt[H_B] = cy_b3;
        end
        2'd2: begin
          nxt[C_B] = cy_msb;
          nxt[V_B] = r_s ^ a_neg;
        end
        default: nxt[V_B] = 1'b0;
      endcase
    end
    case (cmd)
      3'd1: nxt[C_B] = 1'b1;
      3'd2: nxt[C_B] = 1'b0;
      3'd3: nxt[C_B] = ~nxt[C_B];
      3'd4: nxt[DP_B] = 1'b1;
      3'd5: nxt[DP_B] = 1'b0;
      default: ;
    endcase
    if (pop_ok) nxt = stk[top];
    if (wr_en)  nxt = wr_data;
    nxt[1] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg     <= 8'h00;
      cnt     <= '0;
      stk_err <= 1'b0;
    end else begin
      flg <= nxt;
      if (push_ok) begin
        stk[cnt] <= flg;
        cnt      <= cnt + CW'(1);
      end else if (pop_ok) begin
        cnt <= top;
      end
      if (bad) stk_err <= 1'b1;
    end
  end

  assign flags = flg;
endmodule

module status_flag_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [1:0] op_class,
  input logic       op_word,
  input logic [2:0] cmd,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       irq_push,
  input logic       irq_pop,
  input logic [7:0] flags,
  input logic       stk_err
);
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n) flags[1] == 1'b0);

  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> flags == ($past(wr_data) & 8'hFD));

  p_logic_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_class == 2'd3 && !wr_en && !irq_pop && cmd == 3'd0)
    |=> (flags[7] == $past(flags[7]) && flags[3] == $past(flags[3]) &&
         flags[2] == $past(flags[2]) && !flags[4]));

  p_word_keeps_h_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_word && !wr_en && !irq_pop) |=> flags[2] == $past(flags[2]));

  p_set_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd1 && !wr_en && !irq_pop) |=> flags[7]);

  p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    stk_err |=> stk_err);

  p_dual_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_push && irq_pop) |=> stk_err);
endmodule

bind status_flag_unit status_flag_unit_chk u_chk (.*);

// File: tb/test_status_flag_unit.sv
module test_status_flag_unit;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0, op_word = 1'b0, cy_msb = 1'b0, cy_b3 = 1'b0;
  logic a_neg = 1'b0, b_neg = 1'b0, wr_en = 1'b0, irq_push = 1'b0, irq_pop = 1'b0;
  logic [1:0] op_class = 2'd0;
  logic [15:0] res = 16'h0;
  logic [2:0] cmd = 3'd0;
  logic [7:0] wr_data = 8'h0;
  logic [7:0] flags;
  logic stk_err;
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  status_flag_unit i_status_flag_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
    .op_word(op_word), .res(res), .cy_msb(cy_msb), .cy_b3(cy_b3),
    .a_neg(a_neg), .b_neg(b_neg), .cmd(cmd), .wr_en(wr_en), .wr_data(wr_data),
    .irq_push(irq_push), .irq_pop(irq_pop), .flags(flags), .stk_err(stk_err));

  // {class, word, a_neg, b_neg, res, cy_msb, cy_b3, init, expected}
  localparam logic [38:0] VEC [12] = '{
    {2'd0, 1'b0, 1'b0, 1'b0, 16'h0080, 1'b0, 1'b1, 8'h00, 8'h34},
    {2'd0, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b1, 8'h00, 8'hC4},
    {2'd1, 1'b0, 1'b0, 1'b0, 16'h000F, 1'b0, 1'b1, 8'h01, 8'h0D},
    {2'd1, 1'b0, 1'b1, 1'b0, 16'h007F, 1'b0, 1'b1, 8'h00, 8'h1C},
    {2'd0, 1'b1, 1'b0, 1'b0, 16'h8000, 1'b0, 1'b1, 8'h0C, 8'h34},
    {2'd0, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b1, 8'h00, 8'hC0},
    {2'd3, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 8'hFD, 8'hCD},
    {2'd3, 1'b1, 1'b0, 1'b0, 16'h8000, 1'b0, 1'b0, 8'h10, 8'h20},
    {2'd2, 1'b0, 1'b1, 1'b0, 16'h0002, 1'b1, 1'b0, 8'h0D, 8'h9D},
    {2'd0, 1'b0, 1'b0, 1'b0, 16'hFF00, 1'b0, 1'b0, 8'h00, 8'h40},
    {2'd2, 1'b1, 1'b0, 1'b0, 16'h8000, 1'b0, 1'b0, 8'h00, 8'h30},
    {2'd1, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 8'h04, 8'h4C}
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic do_cmd(input logic [2:0] c);
    cmd = c;
    tick();
    cmd = 3'd0;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    tick();
    do_reset();
    check(flags, 8'h00, "R1 reset value");
    check({7'd0, stk_err}, 8'h00, "R1 reset error clear");

    wr(8'hFF);
    check(flags, 8'hFD, "R2 reserved bit reads 0");

    // vector walk: R3 R4 R5 R6 R7 R8
    foreach (VEC[i]) begin
      wr(VEC[i][15:8]);
      op_valid = 1'b1;
      {op_class, op_word, a_neg, b_neg, res, cy_msb, cy_b3} = VEC[i][38:16];
      tick();
      op_valid = 1'b0;
      check(flags, VEC[i][7:0], $sformatf("R3 R4 R5 R6 R7 R8 vector %0d", i));
    end

    wr(8'h00);
    do_cmd(3'd1); check(flags, 8'h80, "R9 set carry");
    do_cmd(3'd3); check(flags, 8'h00, "R9 toggle carry to 0");
    do_cmd(3'd3); check(flags, 8'h80, "R9 toggle carry to 1");
    do_cmd(3'd2); check(flags, 8'h00, "R9 clear carry");
    do_cmd(3'd4); check(flags, 8'h01, "R9 set DP");
    do_cmd(3'd5); check(flags, 8'h00, "R9 clear DP");

    wr_en = 1'b1; wr_data = 8'h02; op_valid = 1'b1; op_class = 2'd0;
    op_word = 1'b0; res = 16'h0000; cy_msb = 1'b1; cmd = 3'd4;
    tick();
    wr_en = 1'b0; op_valid = 1'b0; cmd = 3'd0;
    check(flags, 8'h00, "R10 write overrides update and command");

    do_reset();
    irq_pop = 1'b1; tick(); irq_pop = 1'b0;
    check({7'd0, stk_err}, 8'h01, "R12 pop on empty flags error");
    check(flags, 8'h00, "R12 empty pop leaves register");

    do_reset();
    for (int k = 0; k < 7; k++) begin
      wr(8'(((k + 1) << 4) | 1));
      irq_push = 1'b1; tick(); irq_push = 1'b0;
    end
    check({7'd0, stk_err}, 8'h00, "R11 seven pushes without error");
    wr(8'hEE);
    irq_push = 1'b1; tick(); irq_push = 1'b0;
    check({7'd0, stk_err}, 8'h01, "R12 push on full flags error");
    check(flags, 8'hEC, "R12 full push leaves register");
    for (int j = 6; j >= 0; j--) begin
      irq_pop = 1'b1; tick(); irq_pop = 1'b0;
      check(flags, 8'(((j + 1) << 4) | 1), $sformatf("R11 nested restore level %0d", j));
    end
    irq_pop = 1'b1; tick(); irq_pop = 1'b0;
    check(flags, 8'h11, "R12 pop after drain leaves register");
    check({7'd0, stk_err}, 8'h01, "R12 error stays set");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule